// File: doc/BRIEF.md
# LFO-swept biphase clock generator

This block produces a pair of complementary, non-overlapping clock phases for a bucket-brigade delay line in a flanger. The rate of that clock is set by a numerically controlled oscillator: a 20-bit phase accumulator whose most significant bit becomes the clock. The rate is not fixed. It follows a triangle-wave low-frequency oscillator built into the block, so no separate modulation source or voltage-controlled oscillator is needed. With the default 50 MHz system clock, the usable span is 25 kHz to 500 kHz, a 20:1 range. On a 1024-stage delay line this gives delays from 20 ms down to 1 ms.

The sweep produces a 24-bit frequency word from three settings: a center value, a depth, and the oscillator's own rate. The phase accumulator accepts only a 16-bit increment. The 8 bits below the increment are therefore not discarded. At every reload they are added into an 8-bit residual accumulator, and each carry out of it adds one to the increment for that reload. The increment is reloaded on a fixed tick every 256 system clocks. Averaged over many ticks, the frequency then resolves steps 256 times finer than one increment step. The short-term error moves up to the tick rate, which lies far above the audio band.

Top module: `bbd_sweep_clock`

## Requirements
- R1: While `rst_ni` is low, both phase outputs are low and all accumulators and counters are cleared. Release passes through a two-flop synchronizer, so the first state update happens on the third rising clock edge after `rst_ni` goes high; both outputs stay low until then.
- R2: `phi1_o` and `phi2_o` are never high in the same cycle.
- R3: On each clock edge, the next `phi1_o` is (accumulator MSB and not `phi2_o`) and the next `phi2_o` is (not MSB and not `phi1_o`). Every handover therefore has exactly one cycle with both outputs low.
- R4: The 20-bit phase accumulator adds the current 16-bit increment on every clock, so `phi1_o` runs at f_clk * increment / 2^20.
- R5: A free-running 8-bit tick counter starts at 0 after reset, and the tick fires when the counter equals 255. The increment register changes only on the clock edge that ends a tick cycle.
- R6: At a tick, the increment becomes word[23:8] plus the carry out of (residual + word[7:0]). The residual keeps the low 8 bits of that sum.
- R7: The modulation oscillator has a 24-bit phase that adds `lfo_rate_i` every clock. Its triangle is t = phase[22:15] when phase[23] is 0, and 255 - phase[22:15] when phase[23] is 1.
- R8: The unclamped frequency word is `sweep_center_i` + (t - 128) * `sweep_depth_i` * 64, sampled in the tick cycle.
- R9: The word is clamped to the range 134218 to 2684355, which is 25 kHz to 500 kHz at a 50 MHz system clock.
- R10: With `sweep_depth_i` = 0, the word equals the clamped center and does not depend on the oscillator phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lfo_rate_i | input | 16 | Phase step added to the modulation oscillator every clock |
| sweep_depth_i | input | 8 | Scale applied to the bipolar triangle |
| sweep_center_i | input | 24 | Frequency word at the middle of the sweep |
| phi1_o | output | 1 | First clock phase |
| phi2_o | output | 1 | Second clock phase, complementary to the first with a dead cycle |

## Verification
The output-overlap and dead-cycle properties assume that the accumulator MSB never toggles on two consecutive clocks. That holds only while the increment stays far below half the accumulator range. The range property relies on the clamp limits, which keep the word below the point where a carry could overflow the 16-bit increment. The stimulus holds these assumptions by keeping every center, depth and rate combination inside or near the clamp window. It also drives the clamp edges on purpose with centers above and below the window, so the window is exercised rather than bypassed. The settings change only at falling edges, and the block samples them at rising edges only, so the setup is always settled.

// File: rtl/bbd_sweep_pkg.sv
package bbd_sweep_pkg;

  // Frequency word for 25 kHz and 500 kHz at a 50 MHz clock, 20-bit phase.
  localparam int unsigned DEF_WORD_MIN = 134218;
  localparam int unsigned DEF_WORD_MAX = 2684355;

  // Fold a sawtooth slice into a triangle: rising half passes, falling half inverts.
  function automatic logic [7:0] fold8(input logic half, input logic [7:0] ramp);
    return half ? ~ramp : ramp;
  endfunction

  typedef struct packed {
    logic phi1;
    logic phi2;
  } biphase_t;

endpackage

// File: rtl/bbd_reset_sync.sv
module bbd_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/bbd_lfo_tri.sv
module bbd_lfo_tri #(
  parameter int PH_W   = 24,
  parameter int RATE_W = 16,
  parameter int TRI_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic [TRI_W-1:0]  tri_o
);

  localparam int TOP = PH_W - 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q + PH_W'(rate_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  generate
    if (TRI_W == 8) begin : g_fold_pkg
      assign tri_o = bbd_sweep_pkg::fold8(ph_q[TOP], ph_q[TOP-1 -: 8]);
    end else begin : g_fold_gen
      assign tri_o = ph_q[TOP] ? ~ph_q[TOP-1 -: TRI_W] : ph_q[TOP-1 -: TRI_W];
    end
  endgenerate

endmodule

// File: rtl/bbd_sweep_map.sv
module bbd_sweep_map #(
  parameter int          TRI_W       = 8,
  parameter int          DEPTH_W     = 8,
  parameter int          WORD_W      = 24,
  parameter int          DEPTH_SHIFT = 6,
  parameter int unsigned WORD_MIN    = 134218,
  parameter int unsigned WORD_MAX    = 2684355
) (
  input  logic [TRI_W-1:0]   tri_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [WORD_W-1:0]  center_i,
  output logic [WORD_W-1:0]  word_o
);

  localparam int PROD_W = TRI_W + DEPTH_W + 2;
  localparam int SUM_W  = WORD_W + 3;
  localparam int MID    = 1 << (TRI_W - 1);

  logic signed [TRI_W:0]    tri_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  offs;
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  lim_lo;
  logic signed [SUM_W-1:0]  lim_hi;

  always_comb begin
    tri_s  = $signed({1'b0, tri_i}) - $signed((TRI_W+1)'(MID));
    prod   = PROD_W'(tri_s) * $signed(PROD_W'({1'b0, depth_i}));
    offs   = SUM_W'(prod) <<< DEPTH_SHIFT;
    sum    = $signed({3'b000, center_i}) + offs;
    lim_lo = $signed(SUM_W'(WORD_MIN));
    lim_hi = $signed(SUM_W'(WORD_MAX));
    if (sum < lim_lo) begin
      word_o = WORD_W'(WORD_MIN);
    end else if (sum > lim_hi) begin
      word_o = WORD_W'(WORD_MAX);
    end else begin
      word_o = sum[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/bbd_dither_loader.sv
module bbd_dither_loader #(
  parameter int INC_W  = 16,
  parameter int FRAC_W = 8,
  parameter int TICK_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [INC_W+FRAC_W-1:0] word_i,
  output logic                    tick_o,
  output logic [INC_W-1:0]        inc_o
);

  localparam int WORD_W = INC_W + FRAC_W;

  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic [FRAC_W-1:0] err_q, err_d;
  logic [INC_W-1:0]  inc_q, inc_d;
  logic [FRAC_W:0]   frac_sum;
  logic              load_en;

  always_comb begin
    cnt_d    = cnt_q + TICK_W'(1);
    load_en  = &cnt_q;
    frac_sum = {1'b0, err_q} + {1'b0, word_i[FRAC_W-1:0]};
    err_d    = frac_sum[FRAC_W-1:0];
    inc_d    = word_i[WORD_W-1:FRAC_W] + INC_W'(frac_sum[FRAC_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      inc_q <= '0;
    end else if (load_en) begin
      err_q <= err_d;
      inc_q <= inc_d;
    end
  end

  assign tick_o = load_en;
  assign inc_o  = inc_q;

endmodule

// File: rtl/bbd_biphase_gen.sv
module bbd_biphase_gen #(
  parameter int ACC_W = 20,
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  output logic             phi1_o,
  output logic             phi2_o
);

  import bbd_sweep_pkg::*;

  logic [ACC_W-1:0] acc_q, acc_d;
  biphase_t         out_q, out_d;
  logic             msb;

  always_comb begin
    acc_d      = acc_q + ACC_W'(inc_i);
    msb        = acc_q[ACC_W-1];
    out_d.phi1 = msb & ~out_q.phi2;
    out_d.phi2 = ~msb & ~out_q.phi1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign phi1_o = out_q.phi1;
  assign phi2_o = out_q.phi2;

endmodule

// File: rtl/bbd_sweep_clock.sv
module bbd_sweep_clock #(
  parameter int          ACC_W       = 20,
  parameter int          INC_W       = 16,
  parameter int          FRAC_W      = 8,
  parameter int          LFO_W       = 24,
  parameter int          RATE_W      = 16,
  parameter int          TRI_W       = 8,
  parameter int          DEPTH_W     = 8,
  parameter int          DEPTH_SHIFT = 6,
  parameter int          TICK_W      = 8,
  parameter int unsigned WORD_MIN    = bbd_sweep_pkg::DEF_WORD_MIN,
  parameter int unsigned WORD_MAX    = bbd_sweep_pkg::DEF_WORD_MAX
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [RATE_W-1:0]        lfo_rate_i,
  input  logic [DEPTH_W-1:0]       sweep_depth_i,
  input  logic [INC_W+FRAC_W-1:0]  sweep_center_i,
  output logic                     phi1_o,
  output logic                     phi2_o
);

  localparam int WORD_W = INC_W + FRAC_W;

  logic              rst_core_n;
  logic [TRI_W-1:0]  tri_w;
  logic [WORD_W-1:0] word_w;
  logic              tick_w;
  logic [INC_W-1:0]  inc_w;

  bbd_reset_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  bbd_lfo_tri #(
    .PH_W   (LFO_W),
    .RATE_W (RATE_W),
    .TRI_W  (TRI_W)
  ) u_lfo (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .rate_i (lfo_rate_i),
    .tri_o  (tri_w)
  );

  bbd_sweep_map #(
    .TRI_W       (TRI_W),
    .DEPTH_W     (DEPTH_W),
    .WORD_W      (WORD_W),
    .DEPTH_SHIFT (DEPTH_SHIFT),
    .WORD_MIN    (WORD_MIN),
    .WORD_MAX    (WORD_MAX)
  ) u_map (
    .tri_i    (tri_w),
    .depth_i  (sweep_depth_i),
    .center_i (sweep_center_i),
    .word_o   (word_w)
  );

  bbd_dither_loader #(
    .INC_W  (INC_W),
    .FRAC_W (FRAC_W),
    .TICK_W (TICK_W)
  ) u_load (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .word_i (word_w),
    .tick_o (tick_w),
    .inc_o  (inc_w)
  );

  bbd_biphase_gen #(
    .ACC_W (ACC_W),
    .INC_W (INC_W)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .inc_i  (inc_w),
    .phi1_o (phi1_o),
    .phi2_o (phi2_o)
  );

endmodule

// File: rtl/bbd_sweep_clock_chk.sv
module bbd_sweep_clock_chk #(
  parameter int          INC_W    = 16,
  parameter int          FRAC_W   = 8,
  parameter int unsigned WORD_MIN = 134218,
  parameter int unsigned WORD_MAX = 2684355
) (
  input logic                    clk_i,
  input logic                    rst_core_n,
  input logic                    phi1_o,
  input logic                    phi2_o,
  input logic                    tick_w,
  input logic [INC_W-1:0]        inc_w,
  input logic [INC_W+FRAC_W-1:0] word_w
);

  localparam logic [INC_W-1:0] INC_LO = INC_W'(WORD_MIN >> FRAC_W);
  localparam logic [INC_W-1:0] INC_HI = INC_W'((WORD_MAX >> FRAC_W) + 1);

  // R1: a cycle held in reset leaves both phases low at the next edge
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_core_n |=> (!phi1_o && !phi2_o));

  // R2
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    !(phi1_o && phi2_o));

  // R3: dead cycle after the first phase drops and before it rises
  a_r3_gap_fall1: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    $fell(phi1_o) |-> !phi2_o);

  a_r3_gap_rise1: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    $rose(phi1_o) |-> !$past(phi2_o));

  // R5: increment only moves after a tick cycle
  a_r5_inc_hold: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    !tick_w |=> $stable(inc_w));

  // R6: loaded increment is the coarse word or one above it
  a_r6_inc_step: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    tick_w |=> ((inc_w == $past(word_w[INC_W+FRAC_W-1:FRAC_W])) ||
                (inc_w == $past(word_w[INC_W+FRAC_W-1:FRAC_W]) + INC_W'(1))));

  // R9: every loaded increment lies within the clamp window
  a_r9_inc_range: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    tick_w |=> ((inc_w >= INC_LO) && (inc_w <= INC_HI)));

endmodule

bind bbd_sweep_clock bbd_sweep_clock_chk #(
  .INC_W    (INC_W),
  .FRAC_W   (FRAC_W),
  .WORD_MIN (WORD_MIN),
  .WORD_MAX (WORD_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_core_n (rst_core_n),
  .phi1_o     (phi1_o),
  .phi2_o     (phi2_o),
  .tick_w     (tick_w),
  .inc_w      (inc_w),
  .word_w     (word_w)
);

// File: tb/sim_bbd_sweep_clock.sv
`timescale 1ns/1ps
module sim_bbd_sweep_clock;

  localparam int WMIN  = 134218;
  localparam int WMAX  = 2684355;
  localparam int LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rate = '0;
  logic [7:0]  depth = '0;
  logic [23:0] center = '0;
  logic        phi1, phi2;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    edges1 = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  bbd_sweep_clock u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lfo_rate_i     (rate),
    .sweep_depth_i  (depth),
    .sweep_center_i (center),
    .phi1_o         (phi1),
    .phi2_o         (phi2)
  );

  // Behavioural reference: frequency word from the requirement formulas
  function automatic int ref_word(bit [23:0] ph, int dep, int cen);
    int t, v;
    t = ph[23] ? 255 - int'(ph[22:15]) : int'(ph[22:15]);   // R7
    v = cen + (t - 128) * dep * 64;                        // R8
    if (v < WMIN) v = WMIN;                                // R9
    if (v > WMAX) v = WMAX;
    return v;
  endfunction

  bit [23:0] m_ph;
  bit [7:0]  m_tc, m_err;
  bit [15:0] m_inc;
  bit [19:0] m_acc;
  bit        m_a, m_b, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    bit na, nb;
    int w, s;
    if (!rst_n) begin
      m_ph = 0; m_tc = 0; m_err = 0; m_inc = 0; m_acc = 0;
      m_a = 0; m_b = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (!m_s2) begin
        m_ph = 0; m_tc = 0; m_err = 0; m_inc = 0; m_acc = 0; m_a = 0; m_b = 0;
      end else begin
        na = m_acc[19] & ~m_b;                 // R3
        nb = ~m_acc[19] & ~m_a;
        m_acc = m_acc + 20'(m_inc);            // R4
        if (m_tc == 8'd255) begin              // R5
          w = ref_word(m_ph, int'(depth), int'(center));
          s = int'(m_err) + (w & 255);         // R6
          m_err = 8'(s);
          m_inc = 16'((w >> 8) + (s >> 8));
        end
        m_ph = m_ph + 24'(rate);
        m_tc = m_tc + 8'd1;
        m_a = na;
        m_b = nb;
      end
      m_s2 = m_s1;
      m_s1 = 1'b1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  bit p1, p2;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!done) begin
      check({phi1, phi2} == {m_a, m_b}, tag, int'({phi1, phi2}), int'({m_a, m_b}));
      check(!(phi1 && phi2), "R2", int'({phi1, phi2}), 2);
      check(!(p1 && phi2) && !(p2 && phi1), "R3", int'({p1, p2, phi1, phi2}), 0);
      if (phi1 && !p1) edges1++;
      p1 = phi1;
      p2 = phi2;
      if (cyc >= LIMIT) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset holds outputs low, then two synchronizer cycles
    tag = "R1";
    run(5);
    check(!phi1 && !phi2, "R1", int'({phi1, phi2}), 0);
    rate = 16'h0000; depth = 8'd0; center = 24'h0A0000;
    rst_n = 1'b1;
    run(2);
    check(!phi1 && !phi2, "R1", int'({phi1, phi2}), 0);
    run(1);
    check(phi2 && !phi1, "R3", int'({phi1, phi2}), 1);

    // R4/R10: constant word 0x0A0000 -> increment 2560, 10 periods per 4096 clocks
    tag = "R4/R10";
    run(600);
    edges1 = 0;
    run(4096);
    check(edges1 >= 9 && edges1 <= 11, "R4", edges1, 10);

    // R5/R6: fractional part 0x40 carries every fourth tick
    tag = "R5/R6";
    center = 24'h0A0040;
    run(8192);
    center = 24'h1234C7;
    run(6000);

    // R7/R8: swept triangle within the window
    tag = "R7/R8";
    center = 24'h100000; depth = 8'd100; rate = 16'h0800;
    run(20000);
    rate = 16'h3000; depth = 8'd37;
    run(8000);

    // R9: sweep runs into the upper limit, then centers outside the window
    tag = "R9";
    center = 24'h280000; depth = 8'd255; rate = 16'h1000;
    run(9000);
    center = 24'h020000; depth = 8'd0;
    run(3000);
    center = 24'h300000;
    run(3000);
    center = 24'h000000; depth = 8'd200; rate = 16'h2000;
    run(6000);

    // R1: asynchronous reset in the middle of a run
    tag = "R1";
    #1 rst_n = 1'b0;
    #0.5;
    check(!phi1 && !phi2, "R1", int'({phi1, phi2}), 0);
    run(3);
    check(!phi1 && !phi2, "R1", int'({phi1, phi2}), 0);
    center = 24'h0C0080; depth = 8'd20; rate = 16'h0400;
    rst_n = 1'b1;
    tag = "R1/R6";
    run(10000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule